// File: doc/BRIEF.md
# SPI Packet Receive Deframer

This block sits behind an SPI byte receiver and turns the raw byte stream into message records for a downstream message FIFO. Each accepted byte arrives as a one-cycle strobe with its data. The block emits one record per packet: a 32-bit identifier, a payload byte count, a truncation flag and the payload bytes. The payload is a flat vector with byte k at bits [8k+7:8k].

There are two modes, chosen by `mode_i`. In framed mode (`mode_i`=0) a packet starts with the two-byte start marker 0x55 then 0xAA. An identifier field of selectable width follows, then a count byte, then that many payload bytes. In transparent mode (`mode_i`=1) every byte is payload. A packet closes once the link has been idle for a programmable number of cycles. Its identifier is a default taken from a parameter.

Before a record is written, the FIFO-full input is sampled. A record that meets a full FIFO is dropped, and an overload pulse is raised in its place. The payload store holds `MAX_PAYLOAD` bytes. Longer packets are consumed to their end, keep their first `MAX_PAYLOAD` bytes, and are flagged. Changing `mode_i` abandons any partial packet.

Top module: `spi_deframer`

## Requirements
- R1: While and after reset, with no bytes received, `rec_wr_o` and `overload_o` are 0 and `rec_data_o` is all zero.
- R2: In framed mode a packet starts only on 0x55 immediately followed by 0xAA. Any other byte while searching is discarded. A 0x55 received in place of the 0xAA is itself taken as a new first marker byte, so 0x55 0x55 0xAA opens a packet.
- R3: `id_sel_i`, sampled when the 0xAA is received, sets the identifier width. The value 0 means 4 bytes, assembled most significant byte first. The value 1 means 1 byte, zero-extended to 32 bits. The values 2 and 3 mean no identifier field, and `rec_id_o` is then 0.
- R4: In framed mode the byte after the identifier is the payload count N, and the next N bytes are payload. `rec_wr_o` pulses for one cycle, in the cycle after the edge that accepts the last payload byte. Payload byte k appears at `rec_data_o[8k+7:8k]`, bytes past the count read as zero, and `rec_len_o` equals N.
- R5: A count byte of 0 completes the packet in the cycle after the count byte is accepted, with `rec_len_o`=0, an all-zero payload and `rec_trunc_o`=0.
- R6: A framed count N greater than `MAX_PAYLOAD` consumes all N bytes and emits a single record. That record keeps the first `MAX_PAYLOAD` bytes and has `rec_len_o`=`MAX_PAYLOAD` and `rec_trunc_o`=1. Otherwise `rec_trunc_o`=0.
- R7: In transparent mode every byte is payload, in arrival order. With an idle limit L (0 treated as 1), `rec_wr_o` pulses in the cycle after the L-th consecutive idle clock edge that follows the last byte. The record carries `rec_id_o`=`DEF_ID` and `rec_len_o` equal to the number of bytes.
- R8: In transparent mode each received byte restarts the idle count. Gaps shorter than L cycles therefore do not split a packet.
- R9: A transparent packet of more than `MAX_PAYLOAD` bytes emits one record with the first `MAX_PAYLOAD` bytes, `rec_len_o`=`MAX_PAYLOAD` and `rec_trunc_o`=1.
- R10: When `fifo_full_i` is 1 at the completing edge, `overload_o` pulses in the cycle where `rec_wr_o` would have. `rec_wr_o` stays 0, and the next packet is processed normally.
- R11: In transparent mode the idle count runs only while a partial packet is held. Long idle periods with no bytes produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| mode_i | input | 1 | 0 framed, 1 transparent |
| id_sel_i | input | 2 | Identifier width: 0 four bytes, 1 one byte, 2/3 none |
| tmo_limit_i | input | TMO_W | Transparent idle limit in cycles |
| fifo_full_i | input | 1 | Message FIFO full |
| rec_wr_o | output | 1 | Record write strobe |
| rec_id_o | output | 32 | Record identifier |
| rec_len_o | output | LEN_W | Stored payload byte count |
| rec_trunc_o | output | 1 | Packet exceeded the payload store |
| rec_data_o | output | 8*MAX_PAYLOAD | Payload, byte k at bits [8k+7:8k] |
| overload_o | output | 1 | Record dropped because the FIFO was full |

## Verification
The bench builds the block with `MAX_PAYLOAD`=8, `TMO_W`=4 and a distinctive `DEF_ID`. With a store this small, every count from 0 to 10 can be swept against every identifier width, which covers the exact-fit and over-length boundaries. In transparent mode the idle limits 0 to 3 are each crossed with packet sizes 1 to 10, with and without gaps one cycle short of the limit. This exercises the restart of the idle count, the record timing at each limit, and truncation.

// File: rtl/spi_df_pkg.sv
package spi_df_pkg;
  localparam logic [7:0] MARK0 = 8'h55;
  localparam logic [7:0] MARK1 = 8'hAA;

  typedef enum logic [2:0] {
    FS_HUNT,
    FS_MARK1,
    FS_ID,
    FS_CNT,
    FS_DATA
  } frm_state_e;

  function automatic logic [2:0] id_width(input logic [1:0] sel);
    case (sel)
      2'd0:    id_width = 3'd4;
      2'd1:    id_width = 3'd1;
      default: id_width = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_df_frame.sv
module spi_df_frame
  import spi_df_pkg::*;
#(
  parameter int MAX_PAYLOAD = 64,
  parameter int IDX_W = $clog2(MAX_PAYLOAD),
  parameter int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [7:0]       byte_i,
  input  logic [1:0]       id_sel_i,
  output logic             buf_wr_o,
  output logic [IDX_W-1:0] buf_idx_o,
  output logic             buf_clr_o,
  output logic             done_o,
  output logic [31:0]      id_o,
  output logic [LEN_W-1:0] len_o,
  output logic             trunc_o
);
  localparam logic [7:0] MAX_B = 8'(MAX_PAYLOAD);

  frm_state_e st_q;
  logic [31:0] id_q;
  logic [2:0]  idcnt_q;
  logic [7:0]  cnt_q;
  logic [7:0]  rcv_q;
  logic [7:0]  cnt_src;
  logic        take;
  logic [2:0]  nid;

  assign take = en_i & vld_i;
  assign nid  = id_width(id_sel_i);

  always_comb begin
    buf_wr_o  = 1'b0;
    buf_clr_o = 1'b0;
    done_o    = 1'b0;
    buf_idx_o = rcv_q[IDX_W-1:0];
    if (take && st_q == FS_CNT) begin
      buf_clr_o = 1'b1;
      done_o    = (byte_i == 8'd0);
    end
    if (take && st_q == FS_DATA) begin
      buf_wr_o = (rcv_q < MAX_B);
      done_o   = (rcv_q == cnt_q - 8'd1);
    end
  end

  // count seen by the record: the live byte when it is the count itself
  assign cnt_src = (st_q == FS_CNT) ? byte_i : cnt_q;
  assign trunc_o = (cnt_src > MAX_B);
  assign len_o   = trunc_o ? LEN_W'(MAX_PAYLOAD) : LEN_W'(cnt_src);
  assign id_o    = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_HUNT;
      id_q    <= '0;
      idcnt_q <= '0;
      cnt_q   <= '0;
      rcv_q   <= '0;
    end else if (!en_i) begin
      st_q <= FS_HUNT;
    end else if (vld_i) begin
      case (st_q)
        FS_HUNT: if (byte_i == MARK0) st_q <= FS_MARK1;
        FS_MARK1: begin
          if (byte_i == MARK1) begin
            id_q    <= '0;
            idcnt_q <= nid;
            st_q    <= (nid == 3'd0) ? FS_CNT : FS_ID;
          end else if (byte_i != MARK0) begin
            st_q <= FS_HUNT;
          end
        end
        FS_ID: begin
          id_q    <= {id_q[23:0], byte_i};
          idcnt_q <= idcnt_q - 3'd1;
          if (idcnt_q == 3'd1) st_q <= FS_CNT;
        end
        FS_CNT: begin
          cnt_q <= byte_i;
          rcv_q <= '0;
          st_q  <= (byte_i == 8'd0) ? FS_HUNT : FS_DATA;
        end
        FS_DATA: begin
          rcv_q <= rcv_q + 8'd1;
          if (rcv_q == cnt_q - 8'd1) st_q <= FS_HUNT;
        end
        default: st_q <= FS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/spi_df_xpar.sv
module spi_df_xpar #(
  parameter int MAX_PAYLOAD = 64,
  parameter int TMO_W = 16,
  parameter int IDX_W = $clog2(MAX_PAYLOAD),
  parameter int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             buf_wr_o,
  output logic [IDX_W-1:0] buf_idx_o,
  output logic             buf_clr_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic             trunc_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PAYLOAD);

  logic [LEN_W-1:0] cnt_q;
  logic             ovf_q;
  logic [TMO_W-1:0] tmr_q;
  logic [TMO_W-1:0] lim;
  logic             take, held, room;

  assign take = en_i & vld_i;
  assign held = (cnt_q != '0);
  assign room = (cnt_q < MAX_L);
  assign lim  = (tmo_limit_i == '0) ? TMO_W'(1) : tmo_limit_i;

  assign done_o    = en_i & held & ~vld_i & (tmr_q == lim - TMO_W'(1));
  assign buf_wr_o  = take & room;
  assign buf_clr_o = take & ~held;
  assign buf_idx_o = cnt_q[IDX_W-1:0];
  assign len_o     = cnt_q;
  assign trunc_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      tmr_q <= '0;
    end else if (!en_i || done_o) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      tmr_q <= '0;
    end else if (take) begin
      tmr_q <= '0;
      if (room) cnt_q <= cnt_q + LEN_W'(1);
      else      ovf_q <= 1'b1;
    end else if (held) begin
      tmr_q <= tmr_q + TMO_W'(1);
    end
  end
endmodule

// File: rtl/spi_df_buf.sv
module spi_df_buf #(
  parameter int MAX_PAYLOAD = 64,
  parameter int IDX_W = $clog2(MAX_PAYLOAD)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [7:0]               din_i,
  output logic [8*MAX_PAYLOAD-1:0] data_o
);
  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             b_q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))     b_q <= din_i;
      else if (clr_i)                          b_q <= '0;
    end
    assign data_o[8*g +: 8] = b_q;
  end
endmodule

// File: rtl/spi_deframer.sv
module spi_deframer #(
  parameter int          MAX_PAYLOAD = 64,
  parameter int          TMO_W       = 16,
  parameter logic [31:0] DEF_ID      = 32'h0000_0000,
  localparam int         IDX_W       = $clog2(MAX_PAYLOAD),
  localparam int         LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     byte_vld_i,
  input  logic [7:0]               byte_i,
  input  logic                     mode_i,
  input  logic [1:0]               id_sel_i,
  input  logic [TMO_W-1:0]         tmo_limit_i,
  input  logic                     fifo_full_i,
  output logic                     rec_wr_o,
  output logic [31:0]              rec_id_o,
  output logic [LEN_W-1:0]         rec_len_o,
  output logic                     rec_trunc_o,
  output logic [8*MAX_PAYLOAD-1:0] rec_data_o,
  output logic                     overload_o
);
  logic             f_wr, f_clr, f_done, f_trunc;
  logic [IDX_W-1:0] f_idx;
  logic [31:0]      f_id;
  logic [LEN_W-1:0] f_len;
  logic             x_wr, x_clr, x_done, x_trunc;
  logic [IDX_W-1:0] x_idx;
  logic [LEN_W-1:0] x_len;
  logic             b_wr, b_clr, done;
  logic [IDX_W-1:0] b_idx;

  spi_df_frame #(.MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_frame (
    .clk_i, .rst_ni,
    .en_i(~mode_i), .vld_i(byte_vld_i), .byte_i, .id_sel_i,
    .buf_wr_o(f_wr), .buf_idx_o(f_idx), .buf_clr_o(f_clr),
    .done_o(f_done), .id_o(f_id), .len_o(f_len), .trunc_o(f_trunc)
  );

  spi_df_xpar #(.MAX_PAYLOAD(MAX_PAYLOAD), .TMO_W(TMO_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_xpar (
    .clk_i, .rst_ni,
    .en_i(mode_i), .vld_i(byte_vld_i), .tmo_limit_i,
    .buf_wr_o(x_wr), .buf_idx_o(x_idx), .buf_clr_o(x_clr),
    .done_o(x_done), .len_o(x_len), .trunc_o(x_trunc)
  );

  assign b_wr  = mode_i ? x_wr  : f_wr;
  assign b_clr = mode_i ? x_clr : f_clr;
  assign b_idx = mode_i ? x_idx : f_idx;
  assign done  = mode_i ? x_done : f_done;

  spi_df_buf #(.MAX_PAYLOAD(MAX_PAYLOAD), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .clr_i(b_clr), .wr_i(b_wr), .idx_i(b_idx), .din_i(byte_i),
    .data_o(rec_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_wr_o    <= 1'b0;
      overload_o  <= 1'b0;
      rec_id_o    <= '0;
      rec_len_o   <= '0;
      rec_trunc_o <= 1'b0;
    end else begin
      rec_wr_o   <= done & ~fifo_full_i;
      overload_o <= done & fifo_full_i;
      if (done) begin
        rec_id_o    <= mode_i ? DEF_ID  : f_id;
        rec_len_o   <= mode_i ? x_len   : f_len;
        rec_trunc_o <= mode_i ? x_trunc : f_trunc;
      end
    end
  end
endmodule

// File: rtl/spi_df_chk.sv
module spi_df_chk #(
  parameter int          MAX_PAYLOAD = 64,
  parameter logic [31:0] DEF_ID      = 32'h0,
  parameter int          LEN_W       = $clog2(MAX_PAYLOAD + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_vld_i,
  input logic             mode_i,
  input logic             fifo_full_i,
  input logic             rec_wr_o,
  input logic [31:0]      rec_id_o,
  input logic [LEN_W-1:0] rec_len_o,
  input logic             rec_trunc_o,
  input logic             overload_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PAYLOAD);

  assert_wr_ovl_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rec_wr_o && overload_o));

  assert_ovl_needs_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overload_o |-> $past(fifo_full_i));

  assert_len_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_wr_o |-> rec_len_o <= MAX_L);

  assert_trunc_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_wr_o && rec_trunc_o) |-> rec_len_o == MAX_L);

  assert_xpar_id_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_wr_o && $past(mode_i)) |-> rec_id_o == DEF_ID);

  assert_xpar_idle_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rec_wr_o || overload_o) && $past(mode_i)) |-> !$past(byte_vld_i));

  assert_frame_byte_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rec_wr_o || overload_o) && !$past(mode_i)) |-> $past(byte_vld_i));
endmodule

bind spi_deframer spi_df_chk #(.MAX_PAYLOAD(MAX_PAYLOAD), .DEF_ID(DEF_ID), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .mode_i(mode_i),
  .fifo_full_i(fifo_full_i), .rec_wr_o(rec_wr_o), .rec_id_o(rec_id_o),
  .rec_len_o(rec_len_o), .rec_trunc_o(rec_trunc_o), .overload_o(overload_o)
);

// File: tb/tb_spi_deframer.sv
`timescale 1ns/1ps
module tb_spi_deframer;
  localparam int          MAXP = 8;
  localparam int          TW   = 4;
  localparam logic [31:0] DID  = 32'hA5C3_0F17;
  localparam int          LW   = $clog2(MAXP + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            vld = 1'b0;
  logic [7:0]      bdat = 8'h00;
  logic            mode = 1'b0;
  logic [1:0]      id_sel = 2'd0;
  logic [TW-1:0]   lim = '0;
  logic            full = 1'b0;
  logic            rec_wr, rec_trunc, ovl;
  logic [31:0]     rec_id;
  logic [LW-1:0]   rec_len;
  logic [8*MAXP-1:0] rec_data;

  int nchk = 0, nerr = 0, nrec = 0, novl = 0;
  logic [31:0]     cap_id;
  logic [LW-1:0]   cap_len;
  logic            cap_trunc;
  logic [8*MAXP-1:0] cap_data;

  always #2 clk = ~clk;

  spi_deframer #(.MAX_PAYLOAD(MAXP), .TMO_W(TW), .DEF_ID(DID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(bdat), .mode_i(mode),
    .id_sel_i(id_sel), .tmo_limit_i(lim), .fifo_full_i(full),
    .rec_wr_o(rec_wr), .rec_id_o(rec_id), .rec_len_o(rec_len),
    .rec_trunc_o(rec_trunc), .rec_data_o(rec_data), .overload_o(ovl)
  );

  always @(negedge clk) if (rst_n) begin
    if (rec_wr) begin
      nrec++;
      cap_id = rec_id; cap_len = rec_len; cap_trunc = rec_trunc; cap_data = rec_data;
    end
    if (ovl) novl++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); vld = 1'b1; bdat = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); vld = 1'b0; end
  endtask

  function automatic logic [7:0] pay(input int seed, input int k);
    return 8'(seed * 7 + k * 13 + 1);
  endfunction

  // framed packet: prefix variant by seed, checks timing and record fields
  task automatic frm_pkt(input int sel, input int n, input int seed, input bit fl);
    logic [31:0] eid;
    logic [63:0] edat;
    int r0, o0, nid;
    r0 = nrec; o0 = novl; eid = '0; edat = '0;
    nid = (sel == 0) ? 4 : (sel == 1) ? 1 : 0;
    id_sel = 2'(sel); full = fl;
    if (seed % 3 == 0) begin send(8'h12); send(8'h55); send(8'h31); send(8'hAA); end
    if (seed % 3 == 1) send(8'h55);
    send(8'h55); send(8'hAA);
    for (int i = 0; i < nid; i++) begin
      logic [7:0] ib;
      ib = 8'(seed + 16 * i + 3);
      send(ib);
      eid = {eid[23:0], ib};
    end
    send(8'(n));
    for (int k = 0; k < n; k++) begin
      send(pay(seed, k));
      if (k < MAXP) edat[8*k +: 8] = pay(seed, k);
    end
    @(negedge clk); vld = 1'b0;
    if (fl) begin
      chk($sformatf("R10 overload pulse n=%0d", n), {63'd0, ovl}, 64'd1);
      chk("R10 no write when full", {63'd0, rec_wr}, 64'd0);
      idle(2);
      chk("R10 record dropped", 64'(nrec - r0), 64'd0);
      chk("R10 overload count", 64'(novl - o0), 64'd1);
    end else begin
      chk($sformatf("R4 write timing sel=%0d n=%0d", sel, n), {63'd0, rec_wr}, 64'd1);
      idle(2);
      chk($sformatf("R2 one record sel=%0d n=%0d", sel, n), 64'(nrec - r0), 64'd1);
      chk($sformatf("R3 id sel=%0d", sel), 64'(cap_id), 64'(eid));
      chk($sformatf("R4 R5 R6 len n=%0d", n), 64'(cap_len), 64'((n > MAXP) ? MAXP : n));
      chk($sformatf("R6 trunc n=%0d", n), 64'(cap_trunc), 64'(n > MAXP));
      chk($sformatf("R4 data n=%0d", n), 64'(cap_data), edat);
    end
    full = 1'b0;
  endtask

  // transparent packet with gaps, idle limit l
  task automatic xp_pkt(input int l, input int n, input int gap, input int seed, input bit fl);
    logic [63:0] edat;
    int r0, o0, le;
    bit early;
    r0 = nrec; o0 = novl; edat = '0; early = 1'b0;
    le = (l == 0) ? 1 : l;
    lim = TW'(l); full = fl;
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); vld = 1'b0;
          if (rec_wr || ovl) early = 1'b1;
        end
      end
      send(pay(seed, k));
      if (k < MAXP) edat[8*k +: 8] = pay(seed, k);
    end
    for (int i = 0; i < le; i++) begin
      @(negedge clk); vld = 1'b0;
      if (rec_wr || ovl) early = 1'b1;
    end
    chk($sformatf("R8 no early close l=%0d n=%0d gap=%0d", l, n, gap), {63'd0, early}, 64'd0);
    @(negedge clk);
    if (fl) begin
      chk("R10 transparent overload", {62'd0, ovl, rec_wr}, 64'd2);
      idle(2);
      chk("R10 transparent dropped", 64'(nrec - r0), 64'd0);
    end else begin
      chk($sformatf("R7 close timing l=%0d n=%0d", l, n), {63'd0, rec_wr}, 64'd1);
      idle(2);
      chk("R7 one record", 64'(nrec - r0), 64'd1);
      chk("R7 default id", 64'(cap_id), 64'(DID));
      chk($sformatf("R7 R9 len n=%0d", n), 64'(cap_len), 64'((n > MAXP) ? MAXP : n));
      chk($sformatf("R9 trunc n=%0d", n), 64'(cap_trunc), 64'(n > MAXP));
      chk($sformatf("R7 data n=%0d", n), 64'(cap_data), edat);
    end
    full = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk("R1 write low in reset", {62'd0, rec_wr, ovl}, 64'd0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 write low after reset", {62'd0, rec_wr, ovl}, 64'd0);
    chk("R1 payload zero", 64'(rec_data), 64'd0);

    // R2: noise without a full marker yields nothing
    r0 = nrec;
    send(8'h55); send(8'h12); send(8'hAA); send(8'h03); send(8'h01);
    idle(3);
    chk("R2 noise ignored", 64'(nrec - r0), 64'd0);

    // R3 R4 R5 R6 sweep
    for (int sel = 0; sel < 4; sel++)
      for (int n = 0; n <= MAXP + 2; n++)
        frm_pkt(sel, n, sel * 11 + n, 1'b0);

    frm_pkt(0, 3, 5, 1'b1);
    frm_pkt(1, 2, 6, 1'b0);

    // transparent sweep, R7 R8 R9
    idle(1); mode = 1'b1;
    r0 = nrec;
    idle(30);
    chk("R11 idle holds no record", 64'(nrec - r0), 64'd0);
    for (int l = 0; l < 4; l++)
      for (int n = 1; n <= MAXP + 2; n++)
        xp_pkt(l, n, ((n % 2) == 1 && l > 1) ? l - 1 : 0, l * 17 + n, 1'b0);
    xp_pkt(3, 4, 1, 9, 1'b1);
    xp_pkt(2, 3, 0, 4, 1'b0);
    r0 = nrec;
    idle(40);
    chk("R11 no record after long idle", 64'(nrec - r0), 64'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule